// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block sits beside a DRAM controller and decides when refresh cycles must happen. After reset it keeps the memory untouched for a start-up pause. It then asks the controller for a fixed number of initialization cycles, all of them refreshes. When the last of these has been accepted, it raises `init_done`. From then on it produces one refresh demand per interval. The interval is the retention time divided by the row count, so every row is visited once per retention period.

Requests leave the block on a valid/ready channel. `ref_valid` means at least one refresh is owed. A transfer happens on a clock edge where `ref_valid` and `ref_ready` are both high. Once raised, `ref_valid` stays high until it is accepted, so the controller may hold `ref_ready` low for as long as it is busy.

Demands that arrive while the controller is busy are counted. They are served back to back when it frees up, with the minimum refresh cycle time kept between grants. A sticky `overflow` flag reports a demand that found the count already full.

The controller drives the RAS/CAS pins itself. It takes the CAS-before-RAS lead and hold times and the minimum RAS low and high times from the block's constant outputs, which give those times in clock cycles.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While `rst_n` is low and for PAUSE_US*CLK_MHZ cycles after its release, `ref_valid`, `ref_init`, `init_done` and `overflow` are 0. `ref_valid` first rises after exactly that many rising edges.
- R2: After the pause, exactly INIT_CYCLES requests are accepted with `ref_init` high. `ref_init` is 1 during the whole initialization phase and 0 once it ends.
- R3: `init_done` rises on the edge that accepts the last initialization request and stays 1 until reset.
- R4: The first periodic refresh demand makes `ref_valid` rise exactly RETENTION_US*CLK_MHZ/ROWS cycles (integer division) after the edge that raised `init_done`. Later demands follow at that same period.
- R5: After every accepted request, `ref_valid` stays 0 for RAS_CYC+RP_CYC cycles. Each of these is ceil(ns*CLK_MHZ/1000), with a minimum of 1. With the controller always ready, owed requests are therefore granted exactly RAS_CYC+RP_CYC+1 cycles apart.
- R6: Once `ref_valid` is 1 it does not fall until a transfer takes place.
- R7: Up to BACKLOG_MAX demands that arrive while `ref_ready` is low are kept. All of them are granted back to back once `ref_ready` goes high.
- R8: A demand that arrives while BACKLOG_MAX are already owed and no transfer is happening sets `overflow`. The owed count stays at BACKLOG_MAX. `overflow` stays 1 until reset.
- R9: `cbr_lead_cyc`, `cbr_hold_cyc`, `ras_low_cyc` and `ras_high_cyc` equal ceil(ns*CLK_MHZ/1000), with a minimum of 1, for the parameters CSR_NS, CHR_NS, RAS_NS and RP_NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | output | 1 | A refresh (or an initialization refresh) is requested |
| ref_ready | input | 1 | Controller accepts the request on this edge |
| ref_init | output | 1 | The current request belongs to the start-up sequence |
| init_done | output | 1 | Start-up sequence complete |
| overflow | output | 1 | Sticky: a demand was lost because the backlog was full |
| cbr_lead_cyc | output | PARAM_W | Cycles by which CAS must lead RAS in a CBR refresh |
| cbr_hold_cyc | output | PARAM_W | Cycles CAS stays low after RAS falls |
| ras_low_cyc | output | PARAM_W | Minimum RAS low time in cycles |
| ras_high_cyc | output | PARAM_W | Minimum RAS precharge time in cycles |

## Verification
The bench builds the block with CLK_MHZ=250, PAUSE_US=1, ROWS=64 and RETENTION_US=64. These values give a 250-cycle pause and a 250-cycle refresh period, and the rest stays at its defaults. With them, the whole start-up sequence, several full periods and a backlog filled past BACKLOG_MAX all fit in a few thousand cycles. A draining burst of eight grants at 26-cycle spacing still ends before the next demand arrives, so each grant can be counted exactly.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } seq_phase_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int unsigned RELOAD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic expire
);
  localparam int unsigned W = $clog2(RELOAD + 2);

  logic [W-1:0] cnt;

  assign expire = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= W'(RELOAD);
    else if (restart) cnt <= W'(RELOAD);
    else if (en)      cnt <= (cnt == '0) ? W'(RELOAD) : cnt - 1'b1;
  end

  // Timer never leaves its programmed range (period correctness, R4).
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(RELOAD));

endmodule

// File: rtl/seq_backlog.sv
module seq_backlog #(
  parameter int unsigned MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending,
  output logic overflow
);
  localparam int unsigned W = $clog2(MAX + 1);

  logic [W-1:0] owed;

  assign pending = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed     <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({tick, take})
        2'b10: begin
          if (owed == W'(MAX)) overflow <= 1'b1;
          else                 owed     <= owed + 1'b1;
        end
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assert_backlog_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= W'(MAX));

  assert_take_needs_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> owed != '0);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/seq_spacing.sv
module seq_spacing #(
  parameter int unsigned GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic granted,
  output logic clear
);
  localparam int unsigned W = $clog2(GAP + 1);

  logic [W-1:0] hold;

  assign clear = (hold == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              hold <= '0;
    else if (granted)        hold <= W'(GAP);
    else if (hold != '0)     hold <= hold - 1'b1;
  end

  assert_gap_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    granted |=> !clear);

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned ROWS         = 4096,
  parameter int unsigned RETENTION_US = 64000,
  parameter int unsigned BACKLOG_MAX  = 8,
  parameter int unsigned CSR_NS       = 5,
  parameter int unsigned CHR_NS       = 10,
  parameter int unsigned RAS_NS       = 60,
  parameter int unsigned RP_NS        = 40,
  parameter int unsigned PARAM_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               ref_valid,
  input  logic               ref_ready,
  output logic               ref_init,
  output logic               init_done,
  output logic               overflow,
  output logic [PARAM_W-1:0] cbr_lead_cyc,
  output logic [PARAM_W-1:0] cbr_hold_cyc,
  output logic [PARAM_W-1:0] ras_low_cyc,
  output logic [PARAM_W-1:0] ras_high_cyc
);
  localparam int unsigned PAUSE_CYC    = PAUSE_US * CLK_MHZ;
  localparam int unsigned INTERVAL_CYC = (RETENTION_US * CLK_MHZ) / ROWS;
  localparam int unsigned CSR_CYC      = ns_to_cycles(CSR_NS, CLK_MHZ);
  localparam int unsigned CHR_CYC      = ns_to_cycles(CHR_NS, CLK_MHZ);
  localparam int unsigned RAS_CYC      = ns_to_cycles(RAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC       = ns_to_cycles(RP_NS, CLK_MHZ);
  localparam int unsigned GAP_CYC      = RAS_CYC + RP_CYC;
  localparam int unsigned IW           = $clog2(INIT_CYCLES + 1);

  seq_phase_t    phase;
  logic [IW-1:0] init_left;
  logic          xfer;
  logic          pause_exp;
  logic          tick;
  logic          last_init;
  logic          spaced;
  logic          owed_any;

  assign cbr_lead_cyc = PARAM_W'(CSR_CYC);
  assign cbr_hold_cyc = PARAM_W'(CHR_CYC);
  assign ras_low_cyc  = PARAM_W'(RAS_CYC);
  assign ras_high_cyc = PARAM_W'(RP_CYC);

  assign xfer      = ref_valid && ref_ready;
  assign last_init = xfer && (phase == PH_INIT) && (init_left == IW'(1));
  assign ref_init  = (phase == PH_INIT);

  assign ref_valid = spaced &&
                     (((phase == PH_INIT) && (init_left != '0)) ||
                      ((phase == PH_RUN) && owed_any));

  seq_countdown #(.RELOAD(PAUSE_CYC - 1)) u_pause (
    .clk(clk), .rst_n(rst_n),
    .en(phase == PH_PAUSE), .restart(1'b0), .expire(pause_exp)
  );

  seq_countdown #(.RELOAD(INTERVAL_CYC - 1)) u_interval (
    .clk(clk), .rst_n(rst_n),
    .en(phase == PH_RUN), .restart(last_init), .expire(tick)
  );

  seq_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .take(xfer && (phase == PH_RUN)),
    .pending(owed_any), .overflow(overflow)
  );

  seq_spacing #(.GAP(GAP_CYC)) u_spacing (
    .clk(clk), .rst_n(rst_n), .granted(xfer), .clear(spaced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      init_left <= IW'(INIT_CYCLES);
      init_done <= 1'b0;
    end else begin
      unique case (phase)
        PH_PAUSE: if (pause_exp) phase <= PH_INIT;
        PH_INIT: if (xfer) begin
          init_left <= init_left - 1'b1;
          if (init_left == IW'(1)) begin
            phase     <= PH_RUN;
            init_done <= 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assert_valid_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(xfer));

  assert_init_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_init |-> !init_done);

  assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done && !ref_init |-> !ref_valid);

endmodule

// File: tb/dram_refresh_sequencer_bench.sv
`timescale 1ns/1ps
module dram_refresh_sequencer_bench;
  localparam int MHZ = 250;
  localparam int PUS = 1;
  localparam int NROWS = 64;
  localparam int RET = 64;
  localparam int NINIT = 8;
  localparam int BMAX = 8;

  function automatic int up_cyc(input int ns);
    int c;
    c = (ns * MHZ + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  localparam int P = PUS * MHZ;
  localparam int I = (RET * MHZ) / NROWS;

  // Backlog scenarios: {demands missed, grants expected after release}
  localparam int TAB [4][2] = '{'{1, 1}, '{2, 2}, '{5, 5}, '{8, 8}};

  logic clk = 0;
  logic rst_n = 0;
  logic ref_ready = 0;
  logic ref_valid, ref_init, init_done, overflow;
  logic [7:0] cbr_lead_cyc, cbr_hold_cyc, ras_low_cyc, ras_high_cyc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int G;

  always #2 clk = ~clk;

  dram_refresh_sequencer #(
    .CLK_MHZ(MHZ), .PAUSE_US(PUS), .INIT_CYCLES(NINIT), .ROWS(NROWS),
    .RETENTION_US(RET), .BACKLOG_MAX(BMAX)
  ) u_dram_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_init(ref_init), .init_done(init_done), .overflow(overflow),
    .cbr_lead_cyc(cbr_lead_cyc), .cbr_hold_cyc(cbr_hold_cyc),
    .ras_low_cyc(ras_low_cyc), .ras_high_cyc(ras_high_cyc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until ref_valid is seen high at a falling edge.
  task automatic wait_valid(output int n);
    n = 0;
    while (!ref_valid && n < 5000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  // With ref_ready high, watch `win` edges; count grants and check spacing.
  task automatic drain(input int win, input string req, output int grants);
    int last;
    grants = 0;
    last = -1;
    ref_ready = 1;
    for (int k = 0; k < win; k++) begin
      if (ref_valid) begin
        if (last >= 0) check(k - last == G + 1, "R5 grant spacing", k - last, G + 1);
        last = k;
        grants++;
      end
      @(posedge clk); @(negedge clk);
    end
    ref_ready = 0;
    check(ref_valid == 0, req, ref_valid, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, hs, gr;
    G = up_cyc(60) + up_cyc(40);

    // Reset state (R1) and constant timing outputs (R9)
    repeat (3) @(negedge clk);
    check(ref_valid == 0 && ref_init == 0, "R1 idle in reset", ref_valid, 0);
    check(init_done == 0 && overflow == 0, "R1 flags in reset", init_done, 0);
    check(cbr_lead_cyc == 8'(up_cyc(5)), "R9 cas lead", cbr_lead_cyc, up_cyc(5));
    check(cbr_hold_cyc == 8'(up_cyc(10)), "R9 cas hold", cbr_hold_cyc, up_cyc(10));
    check(ras_low_cyc == 8'(up_cyc(60)), "R9 ras low", ras_low_cyc, up_cyc(60));
    check(ras_high_cyc == 8'(up_cyc(40)), "R9 ras high", ras_high_cyc, up_cyc(40));

    rst_n = 1;
    wait_valid(n);
    check(n == P, "R1 pause length", n, P);
    check(ref_init == 1, "R2 init flag during start-up", ref_init, 1);

    // Start-up sequence (R2, R3, R5)
    hs = 0;
    ref_ready = 1;
    for (int k = 0; k < NINIT * (G + 1) + 10 && !init_done; k++) begin
      if (ref_valid) begin
        hs++;
        if (ref_init != 1) check(0, "R2 init flag on grant", ref_init, 1);
      end
      @(posedge clk); @(negedge clk);
      if (!init_done && hs == NINIT) check(0, "R3 done after last grant", 0, 1);
    end
    ref_ready = 0;
    check(init_done == 1, "R3 init_done raised", init_done, 1);
    check(hs == NINIT, "R2 init grant count", hs, NINIT);
    check(ref_init == 0, "R2 init flag cleared", ref_init, 0);

    // First periodic demand (R4)
    wait_valid(n);
    check(n == I, "R4 first refresh interval", n, I);

    // Backlog table (R4, R6, R7)
    for (int e = 0; e < 4; e++) begin
      if (e > 0) wait_valid(n);
      repeat ((TAB[e][0] - 1) * I) @(posedge clk);
      @(negedge clk);
      check(ref_valid == 1, "R6 request held while not ready", ref_valid, 1);
      drain((TAB[e][0] - 1) * (G + 1) + 30, "R7 backlog emptied", gr);
      check(gr == TAB[e][1], "R7 backlog grants", gr, TAB[e][1]);
      check(init_done == 1, "R3 init_done stays", init_done, 1);
    end

    // Overflow (R8)
    wait_valid(n);
    check(n < I, "R4 periodic demand", n, I);
    repeat (7 * I) @(posedge clk);
    @(negedge clk);
    check(overflow == 0, "R8 no overflow at full", overflow, 0);
    repeat (I) @(posedge clk);
    @(negedge clk);
    check(overflow == 1, "R8 overflow set", overflow, 1);
    drain(7 * (G + 1) + 30, "R8 drained", gr);
    check(gr == BMAX, "R8 count capped", gr, BMAX);
    check(overflow == 1, "R8 overflow sticky", overflow, 1);

    // Reset again (R1)
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(overflow == 0 && init_done == 0, "R1 reset clears flags", overflow, 0);
    rst_n = 1;
    wait_valid(n);
    check(n == P, "R1 pause after second reset", n, P);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule